// File: doc/BRIEF.md
# Charge Pump Boost Mode Controller

This block decides which step-up ratio a multi-ratio charge pump uses: pass-through (1x), 1.5x or 2x. Each LED current channel reports whether its sink is too short of headroom to hold its programmed current. The controller only counts channels that are programmed and are not used as plain switch outputs. Headroom loss on any counted channel must last for a fixed number of microsecond ticks before the ratio moves up. The ratio moves one step at a time and never moves down by itself.

The ratio goes back to 1x when software writes a register, when a downward brightness ramp finishes, and at the end of each blink period. Two command bits can pin the ratio to any value. A third command bit shuts the pump down. The pump also shuts down when no channel is enabled or when reset is low. Each time the pump enters 1.5x or 2x, a soft-start level restarts from zero and rises by one per microsecond tick until it reaches full scale. This limits inrush current while the pump output settles.

Top module: `cpm_mode_ctrl`

## Requirements
- R1: While rst_n is low, mode_o is 00, active is 0 and ss_level is 0. After release with at least one channel enabled and cmd_ctl all zero, active is 1 and mode_o is 00 (1x).
- R2: Under automatic control, the mode moves from 00 (1x) to 01 (1.5x) on the QUAL_US-th consecutive us_tick with counted dropout present. It then moves to 10 (2x) after a further QUAL_US such ticks. It stays at 10 while dropout continues. The mode only ever moves up by one step at a time.
- R3: A clock cycle with no counted dropout clears the qualification count, so a later step needs a full QUAL_US ticks again. A mode step also clears the count.
- R4: A channel counts for dropout only when its ch_en bit is 1 and its ch_gpo bit is 0. Dropout on any other channel never changes the mode.
- R5: A one-cycle pulse on reg_write, ramp_down_done or blink_end returns the automatic mode to 00 in the following cycle and clears the qualification count.
- R6: cmd_ctl[1]=1 with cmd_ctl[2]=0 forces 01. cmd_ctl[2]=1 with cmd_ctl[1]=0 forces 10. Both set forces 00. Both clear selects automatic control. Forcing takes effect in the same cycle. While forced, the automatic state is held at 1x.
- R7: cmd_ctl[3]=1, an all-zero ch_en, or a low rst_n makes active 0 and mode_o 00. Each also makes ss_level 0 from the next clock edge on.
- R8: In 1x mode ss_level is SS_US (full scale). In the clock edge after mode_o enters 01 or 10 from any other value, ss_level becomes 0. It then rises by 1 at each us_tick until it saturates at SS_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also forces shutdown |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ch_en | input | NCH | Channel programmed (nonzero current code) mask |
| ch_gpo | input | NCH | Channel used as switch output mask |
| dropout | input | NCH | Per-channel headroom loss flags |
| cmd_ctl | input | 3 (bits 3:1) | Bit 1 force 1.5x, bit 2 force 2x, bit 3 shutdown |
| reg_write | input | 1 | Pulse: a register was updated |
| ramp_down_done | input | 1 | Pulse: downward brightness ramp finished |
| blink_end | input | 1 | Pulse: blink period finished |
| mode_o | output | 2 | Pump ratio: 00 1x, 01 1.5x, 10 2x |
| active | output | 1 | Pump enabled |
| ss_level | output | $clog2(SS_US+1) | Soft-start current limit level |

## Verification
The case that is hardest to reach from the ports is a 1.5x to 2x step that follows a return event or a dropout gap. A qualification count that was not cleared would make the step come early. The stimulus holds dropout for several hundred ticks. It then inserts a single gap cycle, or a reg_write, blink_end or ramp_down_done pulse, and checks that no step occurs one tick before the full window and that a step does occur exactly at it. Ignored channels are checked the same way: the bench holds dropout on gated-off channels well past the window before it adds a counted channel.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;

  typedef enum logic [1:0] {
    PM_1X   = 2'b00,
    PM_1P5X = 2'b01,
    PM_2X   = 2'b10
  } pump_mode_e;

  // One step up the ratio ladder, saturating at 2x.
  function automatic pump_mode_e mode_step_up(pump_mode_e cur);
    case (cur)
      PM_1X:   return PM_1P5X;
      default: return PM_2X;
    endcase
  endfunction

  // Resolve the two force bits against the automatic choice.
  function automatic pump_mode_e mode_select(logic f15, logic f2, pump_mode_e auto_m);
    case ({f2, f15})
      2'b01:   return PM_1P5X;
      2'b10:   return PM_2X;
      2'b11:   return PM_1X;
      default: return auto_m;
    endcase
  endfunction

  // Saturating linear ramp advanced by one per tick.
  function automatic int ramp_next(int cur, int full, logic tick);
    if (tick && cur < full) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/cpm_dropout_qual.sv
`timescale 1ns/1ps
module cpm_dropout_qual #(
  parameter int NCH     = 18,
  parameter int QUAL_US = 400,
  localparam int QW     = $clog2(QUAL_US + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           us_tick,
  input  logic [NCH-1:0] dropout,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_gpo,
  output logic           any_drop,
  output logic           step
);
  logic [NCH-1:0] counted;
  logic [QW-1:0]  timer_q;

  for (genvar i = 0; i < NCH; i++) begin : g_gate
    assign counted[i] = dropout[i] & ch_en[i] & ~ch_gpo[i];
  end

  assign any_drop = |counted;
  assign step     = ~clr & any_drop & us_tick & (timer_q == QW'(QUAL_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (clr || !any_drop) begin
      timer_q <= '0;
    end else if (us_tick) begin
      if (step) timer_q <= '0;
      else      timer_q <= timer_q + QW'(1);
    end
  end
endmodule

// File: rtl/cpm_mode_fsm.sv
`timescale 1ns/1ps
module cpm_mode_fsm
  import cpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       forced,
  input  logic       back_to_1x,
  input  logic       step,
  output pump_mode_e auto_mode
);
  pump_mode_e auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= PM_1X;
    end else if (!active || forced || back_to_1x) begin
      auto_q <= PM_1X;
    end else if (step) begin
      auto_q <= mode_step_up(auto_q);
    end
  end

  assign auto_mode = auto_q;
endmodule

// File: rtl/cpm_soft_start.sv
`timescale 1ns/1ps
module cpm_soft_start
  import cpm_pkg::*;
#(
  parameter int SS_US = 125,
  localparam int SSW  = $clog2(SS_US + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           us_tick,
  input  pump_mode_e     mode_now,
  output logic           boost_entry,
  output logic [SSW-1:0] ss_level
);
  pump_mode_e     prev_q;
  logic [SSW-1:0] ss_q;

  assign boost_entry = (mode_now != PM_1X) && (mode_now != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= PM_1X;
      ss_q   <= '0;
    end else begin
      prev_q <= mode_now;
      if (!active)                 ss_q <= '0;
      else if (mode_now == PM_1X)  ss_q <= SSW'(SS_US);
      else if (boost_entry)        ss_q <= '0;
      else                         ss_q <= SSW'(ramp_next(int'(ss_q), SS_US, us_tick));
    end
  end

  assign ss_level = ss_q;
endmodule

// File: rtl/cpm_mode_ctrl.sv
`timescale 1ns/1ps
module cpm_mode_ctrl
  import cpm_pkg::*;
#(
  parameter int NCH     = 18,
  parameter int QUAL_US = 400,
  parameter int SS_US   = 125,
  localparam int SSW    = $clog2(SS_US + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           us_tick,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_gpo,
  input  logic [NCH-1:0] dropout,
  input  logic [3:1]     cmd_ctl,
  input  logic           reg_write,
  input  logic           ramp_down_done,
  input  logic           blink_end,
  output logic [1:0]     mode_o,
  output logic           active,
  output logic [SSW-1:0] ss_level
);
  logic       forced;
  logic       back_to_1x;
  logic       qual_clr;
  logic       any_drop;
  logic       step;
  logic       boost_entry;
  pump_mode_e auto_mode;
  pump_mode_e mode_now;

  assign active     = rst_n & ~cmd_ctl[3] & (|ch_en);
  assign forced     = cmd_ctl[1] | cmd_ctl[2];
  assign back_to_1x = reg_write | ramp_down_done | blink_end;
  assign qual_clr   = ~active | forced | back_to_1x;

  cpm_dropout_qual #(.NCH(NCH), .QUAL_US(QUAL_US)) qual_i (
    .clk(clk), .rst_n(rst_n), .clr(qual_clr), .us_tick(us_tick),
    .dropout(dropout), .ch_en(ch_en), .ch_gpo(ch_gpo),
    .any_drop(any_drop), .step(step)
  );

  cpm_mode_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .active(active), .forced(forced),
    .back_to_1x(back_to_1x), .step(step), .auto_mode(auto_mode)
  );

  assign mode_now = active ? mode_select(cmd_ctl[1], cmd_ctl[2], auto_mode) : PM_1X;
  assign mode_o   = mode_now;

  cpm_soft_start #(.SS_US(SS_US)) ss_i (
    .clk(clk), .rst_n(rst_n), .active(active), .us_tick(us_tick),
    .mode_now(mode_now), .boost_entry(boost_entry), .ss_level(ss_level)
  );
endmodule

// File: rtl/cpm_mode_ctrl_chk.sv
`timescale 1ns/1ps
module cpm_mode_ctrl_chk #(
  parameter int SSW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           active,
  input logic           forced,
  input logic           step,
  input logic           boost_entry,
  input logic           reg_write,
  input logic           ramp_down_done,
  input logic           blink_end,
  input logic [1:0]     mode_o,
  input logic [SSW-1:0] ss_level
);
  AST_STEP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !forced && !$past(forced) &&
     mode_o != $past(mode_o) && mode_o != 2'b00) |-> $past(step)); // R2

  AST_ONE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !forced && !$past(forced) &&
     mode_o != $past(mode_o) && mode_o != 2'b00) |-> (mode_o == $past(mode_o) + 2'd1)); // R2

  AST_BACK_TO_1X: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !forced && (reg_write || ramp_down_done || blink_end))
      |=> (mode_o == 2'b00 || forced || !active)); // R5

  AST_IDLE_NO_SS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (ss_level == '0)); // R7

  AST_SS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_entry && active) |=> (ss_level == '0)); // R8
endmodule

bind cpm_mode_ctrl cpm_mode_ctrl_chk #(.SSW(SSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .active(active), .forced(forced), .step(step),
  .boost_entry(boost_entry), .reg_write(reg_write),
  .ramp_down_done(ramp_down_done), .blink_end(blink_end),
  .mode_o(mode_o), .ss_level(ss_level)
);

// File: tb/cpm_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpm_mode_ctrl_tb_top;
  localparam int NCH  = 18;
  localparam int QUAL = 400;
  localparam int FULL = 125;
  localparam int SSW  = $clog2(FULL + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           us_tick = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH-1:0] ch_gpo = '0;
  logic [NCH-1:0] dropout = '0;
  logic [3:1]     cmd = '0;
  logic           reg_write = 1'b0;
  logic           ramp_down_done = 1'b0;
  logic           blink_end = 1'b0;
  logic [1:0]     mode_o;
  logic           active;
  logic [SSW-1:0] ss_level;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int m_auto = 0, m_timer = 0, m_ss = 0, m_prev = 0;

  always #10 clk = ~clk;

  cpm_mode_ctrl #(.NCH(NCH), .QUAL_US(QUAL), .SS_US(FULL)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ch_en(ch_en),
    .ch_gpo(ch_gpo), .dropout(dropout), .cmd_ctl(cmd),
    .reg_write(reg_write), .ramp_down_done(ramp_down_done),
    .blink_end(blink_end), .mode_o(mode_o), .active(active),
    .ss_level(ss_level)
  );

  function automatic bit exp_active();
    return rst_n && !cmd[3] && (ch_en != 0);
  endfunction

  function automatic int exp_mode();
    if (!exp_active()) return 0;
    if (cmd[1] && !cmd[2]) return 1;
    if (cmd[2] && !cmd[1]) return 2;
    if (cmd[2] && cmd[1]) return 0;
    return m_auto;
  endfunction

  always @(posedge clk) begin
    int  mo;
    bit  act, frc, evt, cdo;
    act = exp_active();
    frc = cmd[1] || cmd[2];
    evt = reg_write || ramp_down_done || blink_end;
    cdo = ((dropout & ch_en & ~ch_gpo) != 0);
    mo  = exp_mode();
    if (!rst_n) begin
      m_auto = 0; m_timer = 0; m_ss = 0; m_prev = 0;
    end else begin
      if (!act || frc || evt) begin
        m_timer = 0; m_auto = 0;
      end else if (!cdo) begin
        m_timer = 0;
      end else if (us_tick) begin
        if (m_timer == QUAL - 1) begin
          m_timer = 0;
          if (m_auto < 2) m_auto = m_auto + 1;
        end else begin
          m_timer = m_timer + 1;
        end
      end
      if (!act) m_ss = 0;
      else if (mo == 0) m_ss = FULL;
      else if (mo != m_prev) m_ss = 0;
      else if (us_tick && m_ss < FULL) m_ss = m_ss + 1;
      m_prev = mo;
    end
  end

  always @(negedge clk) begin
    int es;
    es = rst_n ? m_ss : 0;
    n_cmp++;
    if (int'(mode_o) != exp_mode() || active != exp_active() || int'(ss_level) != es) begin
      n_bad++;
      $display("FAIL %s cycle compare: mode %0d/%0d active %0d/%0d ss %0d/%0d (actual/expected)",
               cur_req, mode_o, exp_mode(), active, exp_active(), ss_level, es);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, string what, int act_v, int exp_v);
    @(negedge clk);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic pulse_reg_write();
    reg_write = 1'b1; cyc(1); reg_write = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1", "mode in reset", int'(mode_o), 0);
    chk("R1", "active in reset", int'(active), 0);
    chk("R1", "ss in reset", int'(ss_level), 0);
    rst_n = 1'b1; ch_en = '1; cyc(1);
    chk("R1", "active after release", int'(active), 1);
    chk("R1", "mode after release", int'(mode_o), 0);
    chk("R8", "ss full in 1x", int'(ss_level), FULL);

    cur_req = "R2"; us_tick = 1'b1; dropout = 18'h1;
    cyc(QUAL - 1); chk("R2", "no step one tick early", int'(mode_o), 0);
    cyc(1);        chk("R2", "step to 1.5x", int'(mode_o), 1);
    cyc(1);        chk("R8", "ss restart on entry", int'(ss_level), 0);
    cyc(10);       chk("R8", "ss after 10 ticks", int'(ss_level), 10);
    cyc(QUAL - 12); chk("R2", "still 1.5x", int'(mode_o), 1);
    cyc(1);        chk("R2", "step to 2x", int'(mode_o), 2);
    cyc(500);      chk("R2", "saturate at 2x", int'(mode_o), 2);

    cur_req = "R5"; pulse_reg_write();
    chk("R5", "reg_write returns 1x", int'(mode_o), 0);
    cyc(QUAL - 1); chk("R5", "count cleared by event", int'(mode_o), 0);
    cyc(1);        chk("R5", "step after event", int'(mode_o), 1);
    blink_end = 1'b1; cyc(1); blink_end = 1'b0;
    chk("R5", "blink_end returns 1x", int'(mode_o), 0);
    cyc(QUAL); chk("R5", "step again", int'(mode_o), 1);
    ramp_down_done = 1'b1; cyc(1); ramp_down_done = 1'b0;
    chk("R5", "ramp_down_done returns 1x", int'(mode_o), 0);
    dropout = '0; cyc(2);

    cur_req = "R3"; dropout = 18'h2_0000;
    cyc(300); dropout = '0; cyc(1); dropout = 18'h2_0000;
    cyc(300); chk("R3", "gap cleared count", int'(mode_o), 0);
    cyc(100); chk("R3", "full window after gap", int'(mode_o), 1);
    dropout = '0; pulse_reg_write(); cyc(1);

    cur_req = "R4"; ch_gpo = 18'h20; ch_en = 18'h3FF7F; dropout = 18'hA0;
    cyc(QUAL + 100); chk("R4", "ignored channels", int'(mode_o), 0);
    dropout = 18'hE0;
    cyc(QUAL); chk("R4", "counted channel steps", int'(mode_o), 1);
    dropout = '0; pulse_reg_write(); ch_gpo = '0; ch_en = '1; cyc(1);

    cur_req = "R6"; cmd = 3'b001; cyc(1);
    chk("R6", "force 1.5x", int'(mode_o), 1);
    chk("R8", "ss restart forced 1.5x", int'(ss_level), 0);
    cmd = 3'b010; cyc(1);
    chk("R6", "force 2x", int'(mode_o), 2);
    chk("R8", "ss restart 1.5x to 2x", int'(ss_level), 0);
    cmd = 3'b011; cyc(1);
    chk("R6", "both bits force 1x", int'(mode_o), 0);
    cmd = 3'b001; dropout = 18'h4; cyc(QUAL + 100); cmd = 3'b000; cyc(1);
    chk("R6", "auto held at 1x while forced", int'(mode_o), 0);
    dropout = '0; cyc(2);

    cur_req = "R8"; us_tick = 1'b0; cmd = 3'b001; cyc(1);
    for (int k = 0; k < 20; k++) begin
      us_tick = 1'b1; cyc(1); us_tick = 1'b0; cyc(1);
    end
    chk("R8", "ss counts ticks only", int'(ss_level), 20);
    us_tick = 1'b1; cyc(200);
    chk("R8", "ss saturates", int'(ss_level), FULL);
    cmd = 3'b000; cyc(2);

    cur_req = "R7"; cmd = 3'b100; cyc(1);
    chk("R7", "shutdown bit active", int'(active), 0);
    chk("R7", "shutdown bit mode", int'(mode_o), 0);
    chk("R7", "shutdown bit ss", int'(ss_level), 0);
    cmd = 3'b000; ch_en = '0; cyc(1);
    chk("R7", "no channel enabled", int'(active), 0);
    ch_en = '1; cmd = 3'b010; cyc(2);
    rst_n = 1'b0; cyc(1);
    chk("R7", "reset low mode", int'(mode_o), 0);
    chk("R7", "reset low active", int'(active), 0);
    chk("R7", "reset low ss", int'(ss_level), 0);
    cur_req = "R1"; rst_n = 1'b1; cmd = 3'b000; cyc(2);
    chk("R1", "mode after second release", int'(mode_o), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule